// File: doc/BRIEF.md
# Single-Step Trap and Slot Sequencer

This block tracks the position of the next instruction in a processor that fetches 16-byte bundles of three instruction slots. It also turns a retired instruction into a single-step trap when stepping is enabled. Software prepares a saved copy of the status: a step-enable bit, a slot index and a bundle address. A return-from-interruption pulse then loads the live status from that saved copy. While the live step bit is set, exactly one instruction is allowed to retire. The block then raises a one-cycle trap, clears the live step bit and reports where execution would continue.

The continuation point depends on the instruction. For a normal bundle, the slot index counts 0, 1, 2 and then wraps to slot 0 of the next bundle. A long-immediate bundle wraps after slot 1. An instruction from the alternate 32-bit instruction set advances the address by its byte length and leaves the slot index at 0. If the retiring instruction faults, the fault is reported in place of the trap and the position does not move. Both the trap and the fault write the reported position back into the saved copy, so a second return-from-interruption steps the next instruction.

Top module: `sstep_seq`

## Requirements
- R1: After reset the live and saved step bits, slot indices and addresses are 0, `trap_vld` and `fault_vld` are 0 and `issue_ok` is 1.
- R2: A `rfi_pulse` loads the live step bit, slot and address from the saved copy at the next clock edge. A `sav_wr` without `rfi_pulse` changes no live output.
- R3: An accepted, fault-free retire while `live_step` is 1 raises `trap_vld` for exactly one cycle, starting at the next edge. In that same edge `live_step` clears.
- R4: For a normal bundle (`tmpl_long`=0, `alt_isa`=0), retiring slot 0 or 1 keeps the address and increases the slot by one.
- R5: Retiring slot 2 moves the address to the next 16-byte bundle (bits 3:0 cleared, plus 16) and sets the slot to 0.
- R6: With `tmpl_long`=1, retiring slot 1 moves to the next bundle at slot 0, in the same way as R5.
- R7: With `alt_isa`=1, the next address is the current address plus `alt_len` (in bytes) and the slot is 0.
- R8: A retire with `retire_fault`=1 raises `fault_vld` for one cycle and never `trap_vld`. The live position and step bit are unchanged, and `rpt_addr`/`rpt_slot` show the faulting position.
- R9: `issue_ok` is 0 in every cycle in which `trap_vld` or `fault_vld` is 1. A retire presented in such a cycle is ignored.
- R10: With `live_step`=0, a fault-free retire advances the live position per R4 to R7 and raises no trap.
- R11: On a trap, the saved position becomes the reported next position and the saved step bit becomes 1. On a fault, the saved copy becomes the faulting live position and live step bit. Both take priority over a same-cycle `sav_wr`.
- R12: A retire in the same cycle as `rfi_pulse` is ignored: the live status comes from the saved copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sav_wr | input | 1 | Write the saved status copy |
| sav_step_in | input | 1 | Saved step-enable value to write |
| sav_slot_in | input | SW (2) | Saved slot index to write |
| sav_addr_in | input | AW (64) | Saved bundle address to write |
| rfi_pulse | input | 1 | Return from interruption: live status loads the saved copy |
| retire_vld | input | 1 | One instruction retires this cycle |
| retire_fault | input | 1 | The retiring instruction raised a fault |
| tmpl_long | input | 1 | Current bundle is of the long-immediate type |
| alt_isa | input | 1 | Retiring instruction belongs to the alternate 32-bit set |
| alt_len | input | OFS (4) | Byte length of an alternate-set instruction |
| live_step | output | 1 | Live single-step enable |
| live_slot | output | SW (2) | Live slot index |
| live_addr | output | AW (64) | Live bundle address |
| issue_ok | output | 1 | The next instruction may start |
| trap_vld | output | 1 | Single-step trap, one-cycle pulse |
| fault_vld | output | 1 | Stepped or normal instruction fault, one-cycle pulse |
| rpt_slot | output | SW (2) | Reported slot at the last trap or fault |
| rpt_addr | output | AW (64) | Reported address at the last trap or fault |

## Verification
Every result of this block is a register that updates at the first rising edge after its stimulus. The live status after `rfi_pulse`, the trap or fault pulse, the reported position, the rewritten saved copy and the advanced live position after a retire all appear one edge later, and `issue_ok` drops in the same cycle as the pulse. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It compares every output at that falling edge with a model kept in bench functions, and compares again one cycle later to confirm that the pulses last a single cycle. Directed runs step every slot of a normal and a long-immediate bundle. Randomized runs mix saved-copy writes, returns, stepping, faults and alternate-set instructions.

// File: rtl/sstep_pkg.sv
// Shared types for the single-step sequencer.
// Assumes: at most one retire per cycle.
package sstep_pkg;

    // Outcome of the current cycle's retire, as decided by the trap control.
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,   // no accepted retire
        EV_ADV   = 2'd1,   // retire while not stepping: advance only
        EV_STEP  = 2'd2,   // retire while stepping: advance and trap
        EV_FAULT = 2'd3    // retire that faulted: hold position, report fault
    } sstep_ev_e;

endpackage

// File: rtl/sstep_next_pos.sv
// Next-instruction position calculator.
// Computes the address and slot that follow the current instruction.
// A normal bundle ends after its last slot. A long-immediate bundle ends one
// slot earlier. An alternate-set instruction advances by its byte length.
// Assumes BUNDLE_BYTES is a power of two and SLOTS >= 2.
module sstep_next_pos #(
    parameter int AW           = 64,
    parameter int SLOTS        = 3,
    parameter int BUNDLE_BYTES = 16,
    localparam int OFS         = $clog2(BUNDLE_BYTES),
    localparam int SW          = $clog2(SLOTS)
) (
    input  logic [AW-1:0]  cur_addr,
    input  logic [SW-1:0]  cur_slot,
    input  logic           tmpl_long,
    input  logic           alt_isa,
    input  logic [OFS-1:0] alt_len,
    output logic [AW-1:0]  nxt_addr,
    output logic [SW-1:0]  nxt_slot
);

    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
    localparam logic [SW-1:0] LONG_LAST = SW'(SLOTS - 2);

    logic          bundle_end;
    logic [AW-1:0] bundle_next;

    // Decide whether this slot closes the bundle and form the next bundle base.
    always_comb begin
        bundle_end  = (cur_slot >= LAST_SLOT) || (tmpl_long && (cur_slot >= LONG_LAST));
        bundle_next = {cur_addr[AW-1:OFS] + (AW-OFS)'(1), {OFS{1'b0}}};
    end

    // Select the continuation point for the instruction class.
    always_comb begin
        if (alt_isa) begin
            nxt_addr = cur_addr + AW'(alt_len);
            nxt_slot = '0;
        end else if (bundle_end) begin
            nxt_addr = bundle_next;
            nxt_slot = '0;
        end else begin
            nxt_addr = cur_addr;
            nxt_slot = cur_slot + SW'(1);
        end
    end

endmodule

// File: rtl/sstep_trap_ctl.sv
// Trap control for the single-step sequencer.
// Classifies each cycle's retire and raises the one-cycle trap or fault pulse.
// A retire is accepted only outside a return-from-interruption cycle and
// outside a trap or fault cycle. This gives the trap priority over the
// start of the next instruction.
// Assumes the retire strobe is a single-cycle qualifier.
module sstep_trap_ctl
    import sstep_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rfi_pulse,
    input  logic      retire_vld,
    input  logic      retire_fault,
    input  logic      live_step,
    output sstep_ev_e ev,
    output logic      trap_vld,
    output logic      fault_vld,
    output logic      issue_ok
);

    logic accept;

    // Qualify the retire and classify its outcome.
    always_comb begin
        accept = retire_vld && !rfi_pulse && !trap_vld && !fault_vld;
        if (!accept)
            ev = EV_NONE;
        else if (retire_fault)
            ev = EV_FAULT;
        else if (live_step)
            ev = EV_STEP;
        else
            ev = EV_ADV;
    end

    // Register the trap and fault pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_vld  <= 1'b0;
            fault_vld <= 1'b0;
        end else begin
            trap_vld  <= (ev == EV_STEP);
            fault_vld <= (ev == EV_FAULT);
        end
    end

    // Hold off the next instruction while an event is being taken.
    always_comb issue_ok = !(trap_vld || fault_vld);

endmodule

// File: rtl/sstep_status_regs.sv
// Saved and live status registers, plus the reported position.
// The live copy loads from the saved copy on a return from interruption.
// A trap or fault writes the position back into the saved copy.
// Assumes ev is already qualified: no event in a return-from-interruption cycle.
module sstep_status_regs
    import sstep_pkg::*;
#(
    parameter int AW = 64,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sav_wr,
    input  logic          sav_step_in,
    input  logic [SW-1:0] sav_slot_in,
    input  logic [AW-1:0] sav_addr_in,
    input  logic          rfi_pulse,
    input  sstep_ev_e     ev,
    input  logic [AW-1:0] nxt_addr,
    input  logic [SW-1:0] nxt_slot,
    output logic          live_step,
    output logic [SW-1:0] live_slot,
    output logic [AW-1:0] live_addr,
    output logic [SW-1:0] rpt_slot,
    output logic [AW-1:0] rpt_addr
);

    logic          sav_step;
    logic [SW-1:0] sav_slot;
    logic [AW-1:0] sav_addr;

    // Saved copy: an event write-back wins over a write from software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sav_step <= 1'b0;
            sav_slot <= '0;
            sav_addr <= '0;
        end else if (ev == EV_STEP) begin
            sav_step <= 1'b1;
            sav_slot <= nxt_slot;
            sav_addr <= nxt_addr;
        end else if (ev == EV_FAULT) begin
            sav_step <= live_step;
            sav_slot <= live_slot;
            sav_addr <= live_addr;
        end else if (sav_wr) begin
            sav_step <= sav_step_in;
            sav_slot <= sav_slot_in;
            sav_addr <= sav_addr_in;
        end
    end

    // Live copy: a return from interruption restores, a clean retire advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_step <= 1'b0;
            live_slot <= '0;
            live_addr <= '0;
        end else if (rfi_pulse) begin
            live_step <= sav_step;
            live_slot <= sav_slot;
            live_addr <= sav_addr;
        end else if (ev == EV_STEP || ev == EV_ADV) begin
            live_slot <= nxt_slot;
            live_addr <= nxt_addr;
            if (ev == EV_STEP)
                live_step <= 1'b0;
        end
    end

    // Reported position: the next instruction on a trap, the faulting one on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_slot <= '0;
            rpt_addr <= '0;
        end else if (ev == EV_STEP) begin
            rpt_slot <= nxt_slot;
            rpt_addr <= nxt_addr;
        end else if (ev == EV_FAULT) begin
            rpt_slot <= live_slot;
            rpt_addr <= live_addr;
        end
    end

endmodule

// File: rtl/sstep_seq.sv
// Single-step trap and slot sequencer, top level.
// Tracks the next-instruction position across bundles and alternate-set
// instructions. In step mode it lets one instruction retire and then traps.
// Assumes one retire per cycle, 16-byte bundles and three slots by default.
module sstep_seq
    import sstep_pkg::*;
#(
    parameter int  AW           = 64,
    parameter int  SLOTS        = 3,
    parameter int  BUNDLE_BYTES = 16,
    localparam int OFS          = $clog2(BUNDLE_BYTES),
    localparam int SW           = $clog2(SLOTS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sav_wr,
    input  logic           sav_step_in,
    input  logic [SW-1:0]  sav_slot_in,
    input  logic [AW-1:0]  sav_addr_in,
    input  logic           rfi_pulse,
    input  logic           retire_vld,
    input  logic           retire_fault,
    input  logic           tmpl_long,
    input  logic           alt_isa,
    input  logic [OFS-1:0] alt_len,
    output logic           live_step,
    output logic [SW-1:0]  live_slot,
    output logic [AW-1:0]  live_addr,
    output logic           issue_ok,
    output logic           trap_vld,
    output logic           fault_vld,
    output logic [SW-1:0]  rpt_slot,
    output logic [AW-1:0]  rpt_addr
);

    sstep_ev_e     ev;
    logic [AW-1:0] nxt_addr;
    logic [SW-1:0] nxt_slot;

    sstep_next_pos #(
        .AW(AW), .SLOTS(SLOTS), .BUNDLE_BYTES(BUNDLE_BYTES)
    ) u_next (
        .cur_addr (live_addr),
        .cur_slot (live_slot),
        .tmpl_long(tmpl_long),
        .alt_isa  (alt_isa),
        .alt_len  (alt_len),
        .nxt_addr (nxt_addr),
        .nxt_slot (nxt_slot)
    );

    sstep_trap_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rfi_pulse   (rfi_pulse),
        .retire_vld  (retire_vld),
        .retire_fault(retire_fault),
        .live_step   (live_step),
        .ev          (ev),
        .trap_vld    (trap_vld),
        .fault_vld   (fault_vld),
        .issue_ok    (issue_ok)
    );

    sstep_status_regs #(.AW(AW), .SW(SW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sav_wr     (sav_wr),
        .sav_step_in(sav_step_in),
        .sav_slot_in(sav_slot_in),
        .sav_addr_in(sav_addr_in),
        .rfi_pulse  (rfi_pulse),
        .ev         (ev),
        .nxt_addr   (nxt_addr),
        .nxt_slot   (nxt_slot),
        .live_step  (live_step),
        .live_slot  (live_slot),
        .live_addr  (live_addr),
        .rpt_slot   (rpt_slot),
        .rpt_addr   (rpt_addr)
    );

endmodule

// File: rtl/sstep_seq_chk.sv
// Protocol checker for sstep_seq, attached to it with bind.
// Assumes: reset is synchronous and active-low.
module sstep_seq_chk #(
    parameter int AW    = 64,
    parameter int SLOTS = 3,
    parameter int OFS   = 4,
    parameter int SW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          retire_vld,
    input logic          retire_fault,
    input logic          rfi_pulse,
    input logic          alt_isa,
    input logic          live_step,
    input logic [SW-1:0] live_slot,
    input logic          issue_ok,
    input logic          trap_vld,
    input logic          fault_vld,
    input logic [SW-1:0] rpt_slot,
    input logic [AW-1:0] rpt_addr
);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap_vld |=> !trap_vld);

    a_r3_step_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        trap_vld |-> !live_step);

    a_r3_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_vld) |-> $past(retire_vld && live_step && !retire_fault && !rfi_pulse));

    a_r8_no_trap_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_vld && fault_vld));

    a_r8_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_vld) |-> $past(retire_vld && retire_fault));

    a_r9_issue_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_vld || fault_vld) |-> !issue_ok);

    a_r5_bundle_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(trap_vld) && rpt_slot == '0 && !$past(alt_isa)) |-> rpt_addr[OFS-1:0] == '0);

    a_r4_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(live_slot) < SLOTS);

endmodule

bind sstep_seq sstep_seq_chk #(.AW(AW), .SLOTS(SLOTS), .OFS(OFS), .SW(SW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .retire_vld  (retire_vld),
    .retire_fault(retire_fault),
    .rfi_pulse   (rfi_pulse),
    .alt_isa     (alt_isa),
    .live_step   (live_step),
    .live_slot   (live_slot),
    .issue_ok    (issue_ok),
    .trap_vld    (trap_vld),
    .fault_vld   (fault_vld),
    .rpt_slot    (rpt_slot),
    .rpt_addr    (rpt_addr)
);

// File: tb/sstep_seq_tb_top.sv
// Self-checking bench for sstep_seq: directed stepping over every slot plus
// seeded random mixes, compared against a bench-side model.
module sstep_seq_tb_top;

    localparam int AW = 64;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sav_wr = 1'b0, sav_step_in = 1'b0;
    logic [SW-1:0] sav_slot_in = '0;
    logic [AW-1:0] sav_addr_in = '0;
    logic          rfi_pulse = 1'b0, retire_vld = 1'b0, retire_fault = 1'b0;
    logic          tmpl_long = 1'b0, alt_isa = 1'b0;
    logic [3:0]    alt_len = '0;
    logic          live_step, issue_ok, trap_vld, fault_vld;
    logic [SW-1:0] live_slot, rpt_slot;
    logic [AW-1:0] live_addr, rpt_addr;

    int  n_chk = 0, n_fail = 0;
    bit  done = 0;

    // model state
    logic          m_lstep = 0, m_sstep = 0, m_trap = 0, m_fault = 0;
    logic [SW-1:0] m_lslot = 0, m_sslot = 0, m_rslot = 0;
    logic [AW-1:0] m_laddr = 0, m_saddr = 0, m_raddr = 0;

    always #5 clk = ~clk;

    sstep_seq dut_i (.*);

    function automatic logic [AW-1:0] f_naddr(logic [AW-1:0] a, logic [SW-1:0] s,
                                              logic lng, logic alt, logic [3:0] len);
        if (alt) return a + AW'(len);
        if (s == 2'd2 || (lng && s >= 2'd1)) return (a & ~64'hF) + 64'd16;
        return a;
    endfunction

    function automatic logic [SW-1:0] f_nslot(logic [SW-1:0] s, logic lng, logic alt);
        if (alt || s == 2'd2 || (lng && s >= 2'd1)) return 2'd0;
        return s + 2'd1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk(live_step == m_lstep, {tag, " live_step"}, AW'(live_step), AW'(m_lstep));
        chk(live_slot == m_lslot, {tag, " live_slot"}, AW'(live_slot), AW'(m_lslot));
        chk(live_addr == m_laddr, {tag, " live_addr"}, live_addr, m_laddr);
        chk(trap_vld == m_trap, {tag, " trap_vld"}, AW'(trap_vld), AW'(m_trap));
        chk(fault_vld == m_fault, {tag, " fault_vld"}, AW'(fault_vld), AW'(m_fault));
        chk(issue_ok == !(m_trap || m_fault), {tag, " R9 issue_ok"}, AW'(issue_ok),
            AW'(!(m_trap || m_fault)));
        chk(rpt_slot == m_rslot, {tag, " rpt_slot"}, AW'(rpt_slot), AW'(m_rslot));
        chk(rpt_addr == m_raddr, {tag, " rpt_addr"}, rpt_addr, m_raddr);
    endtask

    // One cycle of stimulus, applied at a falling edge and removed at the next;
    // the model advances per R2..R12 and all outputs are compared.
    task automatic cyc(input logic w, input logic st, input logic [SW-1:0] sl,
                       input logic [AW-1:0] a, input logic rfi, input logic ret,
                       input logic lng, input logic alt, input logic [3:0] len,
                       input logic flt, input string tag);
        logic acc, ntrap, nfault;
        logic [AW-1:0] na;
        logic [SW-1:0] ns;
        sav_wr = w; sav_step_in = st; sav_slot_in = sl; sav_addr_in = a;
        rfi_pulse = rfi; retire_vld = ret; tmpl_long = lng; alt_isa = alt;
        alt_len = len; retire_fault = flt;
        @(negedge clk);
        sav_wr = 0; rfi_pulse = 0; retire_vld = 0; retire_fault = 0;
        tmpl_long = 0; alt_isa = 0; alt_len = 0;
        acc    = ret && !rfi && !m_trap && !m_fault;
        na     = f_naddr(m_laddr, m_lslot, lng, alt, len);
        ns     = f_nslot(m_lslot, lng, alt);
        ntrap  = acc && !flt && m_lstep;
        nfault = acc && flt;
        if (ntrap) begin
            m_rslot = ns; m_raddr = na;
        end else if (nfault) begin
            m_rslot = m_lslot; m_raddr = m_laddr;
        end
        if (ntrap) begin
            m_sstep = 1; m_sslot = ns; m_saddr = na;
        end else if (nfault) begin
            m_sstep = m_lstep; m_sslot = m_lslot; m_saddr = m_laddr;
        end else if (w) begin
            m_sstep = st; m_sslot = sl; m_saddr = a;
        end
        if (rfi) begin
            m_lstep = m_sstep_prev; m_lslot = m_sslot_prev; m_laddr = m_saddr_prev;
        end else if (acc && !flt) begin
            m_lslot = ns; m_laddr = na;
            if (ntrap) m_lstep = 0;
        end
        m_trap = ntrap; m_fault = nfault;
        m_sstep_prev = m_sstep; m_sslot_prev = m_sslot; m_saddr_prev = m_saddr;
        check_all(tag);
    endtask

    // saved copy as it stood before the current cycle (R2 restores this)
    logic          m_sstep_prev = 0;
    logic [SW-1:0] m_sslot_prev = 0;
    logic [AW-1:0] m_saddr_prev = 0;

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // Directed step of one instruction from a chosen position.
    task automatic step_one(input logic [SW-1:0] sl, input logic [AW-1:0] a,
                            input logic lng, input logic alt, input logic [3:0] len,
                            input string tag);
        logic [AW-1:0] ea;
        logic [SW-1:0] es;
        ea = f_naddr(a, sl, lng, alt, len);
        es = f_nslot(sl, lng, alt);
        cyc(1, 1, sl, a, 0, 0, 0, 0, 0, 0, {tag, " R2 write"});
        chk(live_step == 0 || m_lstep == live_step, "R2 write leaves live", AW'(live_step), AW'(m_lstep));
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, {tag, " R2 rfi"});
        chk(live_step == 1 && live_slot == sl && live_addr == a, "R2 restore",
            live_addr, a);
        cyc(0, 0, 0, 0, 0, 1, lng, alt, len, 0, tag);
        chk(trap_vld == 1, {tag, " R3 trap"}, AW'(trap_vld), 1);
        chk(live_step == 0, {tag, " R3 step cleared"}, AW'(live_step), 0);
        chk(rpt_addr == ea, {tag, " addr"}, rpt_addr, ea);
        chk(rpt_slot == es, {tag, " slot"}, AW'(rpt_slot), AW'(es));
        idle({tag, " R3 pulse ends"});
        chk(trap_vld == 0, {tag, " R3 one cycle"}, AW'(trap_vld), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 reset");

        // R4/R5: normal bundle, every slot
        step_one(2'd0, 64'h1000, 0, 0, 0, "R4 normal slot0");
        step_one(2'd1, 64'h1000, 0, 0, 0, "R4 normal slot1");
        step_one(2'd2, 64'h1000, 0, 0, 0, "R5 normal slot2");
        // R6: long-immediate bundle
        step_one(2'd0, 64'h2FF0, 1, 0, 0, "R6 long slot0");
        step_one(2'd1, 64'h2FF0, 1, 0, 0, "R6 long slot1");
        // R5 wrap at top of address space
        step_one(2'd2, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0, 0, "R5 wrap");
        // R7: alternate set
        step_one(2'd0, 64'h3003, 0, 1, 4'd7, "R7 alt");

        // R11: trap writes back, so a second rfi steps the next slot
        step_one(2'd0, 64'h4000, 0, 0, 0, "R11 first");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R11 rfi again");
        chk(live_step == 1 && live_slot == 2'd1, "R11 resume slot", AW'(live_slot), 1);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R11 second step");
        chk(rpt_slot == 2'd2 && rpt_addr == 64'h4000, "R11 second report", rpt_addr, 64'h4000);
        idle("R11 idle");

        // R8: fault while stepping
        cyc(1, 1, 2'd1, 64'h5000, 0, 0, 0, 0, 0, 0, "R8 write");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R8 rfi");
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R8 fault");
        chk(fault_vld == 1 && trap_vld == 0, "R8 fault not trap", AW'(trap_vld), 0);
        chk(live_step == 1 && live_slot == 2'd1, "R8 position held", AW'(live_slot), 1);

        // R9: retire during the fault cycle is ignored
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9 blocked retire");
        chk(trap_vld == 0 && live_slot == 2'd1, "R9 ignored", AW'(live_slot), 1);

        // R10: not stepping, retire just advances
        cyc(1, 0, 2'd2, 64'h6000, 0, 0, 0, 0, 0, 0, "R10 write");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R10 rfi");
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R10 advance");
        chk(trap_vld == 0 && live_addr == 64'h6010, "R10 no trap", live_addr, 64'h6010);

        // R12: rfi beats retire in the same cycle
        cyc(1, 1, 2'd0, 64'h7000, 0, 0, 0, 0, 0, 0, "R12 write");
        cyc(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R12 rfi+retire");
        chk(trap_vld == 0 && live_addr == 64'h7000 && live_slot == 0,
            "R12 retire ignored", live_addr, 64'h7000);
        idle("R12 idle");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [AW-1:0] ra;
            op = $urandom % 8;
            ra = {$urandom, $urandom};
            case (op)
                0: cyc(1, 1'($urandom), 2'($urandom % 3), ra, 0, 0, 0, 0, 0, 0, "rnd R2 write");
                1, 2: cyc(0, 0, 0, 0, 1, 1'($urandom), 0, 0, 0, 0, "rnd R12 rfi");
                7: idle("rnd idle");
                default: cyc(1'($urandom % 4 == 0), 1'($urandom), 2'($urandom % 3), ra, 0, 1,
                             1'($urandom), 1'($urandom % 4 == 0), 4'($urandom % 15 + 1),
                             1'($urandom % 5 == 0), "rnd R7 R10 retire");
            endcase
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule